// File: doc/BRIEF.md
# Issue Window Tag Wakeup

This block keeps the waiting instructions of an out-of-order core in a small window. Each slot stores two source tags, which are physical register numbers, and a ready flag for each of them. Each cycle the execution side can put up to IW result tags on parallel broadcast buses. Every slot compares both of its source tags with every bus. A hit on any bus marks that operand ready. A slot whose operands are both ready raises a request to the select logic in the same cycle. This keeps wakeup and select as one combined step, so a dependent instruction can issue in the cycle right after its producer.

Dispatch writes at most one instruction per cycle into the lowest free slot. The block chooses the slot and reports it. A grant from the select logic frees the granted slot on the next clock edge. Tag 0 is reserved to mean "no operand" and always counts as ready. Operand values, the select arbiter and renaming are outside this block.

Top module: `issue_wakeup_window`

## Requirements
- R1: After reset every slot is invalid, every request is low, `disp_ready_o` is 1 and `disp_idx_o` is 0.
- R2: When a bus has its valid bit set and carries a tag equal to a waiting source tag of a valid slot, that operand becomes ready. The slot's request reflects this combinationally in the same cycle, and the ready flag stays set in later cycles.
- R3: A match on any of the IW buses counts. Bus k carries its tag in bits [k*TAG_W +: TAG_W] of `bc_tag_i`. The two operands of one slot can wake in the same cycle from different buses.
- R4: `req_o[i]` is high exactly when slot i is valid and both of its operands are ready, counting wakeups from the current cycle.
- R5: A source whose `disp_rdy_i` bit is 1 (bit 0 for source 0, bit 1 for source 1) enters ready. A source tag equal to 0 always counts as ready.
- R6: A broadcast in the same cycle as a dispatch is compared with the incoming source tags. A match enters the slot already ready.
- R7: A grant on a slot whose request is high clears that slot's valid bit at the next clock edge. A grant on a slot whose request is low has no effect.
- R8: A dispatch (`disp_valid_i` high while `disp_ready_o` is 1) writes the lowest-numbered free slot, whose index is shown on `disp_idx_o`. That slot is valid from the next cycle.
- R9: When all slots are valid, `disp_ready_o` is 0 and a dispatch changes no slot.
- R10: A bus whose valid bit is 0 wakes nothing, and an invalid slot never requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disp_valid_i | input | 1 | Dispatch an instruction this cycle |
| disp_tag_i | input | 2*TAG_W | Source tags: source 0 in the low half, source 1 in the high half |
| disp_rdy_i | input | 2 | Source is already ready at dispatch |
| disp_ready_o | output | 1 | A free slot exists |
| disp_idx_o | output | $clog2(ENTRIES) | Slot that a dispatch would fill |
| bc_valid_i | input | IW | Valid bit for each broadcast bus |
| bc_tag_i | input | IW*TAG_W | Result tags, one per bus |
| grant_i | input | ENTRIES | Issue grant for each slot |
| valid_o | output | ENTRIES | Occupancy of each slot |
| req_o | output | ENTRIES | Issue request for each slot |

## Verification
Requests follow broadcasts with no clock delay. The bench drives a broadcast at the falling edge and checks `req_o` shortly afterwards, before the next rising edge. It checks the same request again one cycle later to confirm that the ready flag was stored. Dispatches, grants and their effect on `valid_o`, `disp_idx_o` and `disp_ready_o` take one rising edge. Those checks are made at the falling edge that follows that rising edge.

// File: rtl/wakeup_pkg.sv
package wakeup_pkg;
  localparam int unsigned OPS = 2;
  typedef enum logic {OP_SRC0 = 1'b0, OP_SRC1 = 1'b1} op_sel_e;
endpackage

// File: rtl/tag_match.sv
module tag_match #(
  parameter int unsigned IW    = 4,
  parameter int unsigned TAG_W = 7
) (
  input  logic                en_i,
  input  logic [TAG_W-1:0]    tag_i,
  input  logic [IW-1:0]       bc_valid_i,
  input  logic [IW*TAG_W-1:0] bc_tag_i,
  output logic                hit_o
);
  logic [IW-1:0] bus_hit;

  for (genvar k = 0; k < IW; k++) begin : g_bus
    assign bus_hit[k] = bc_valid_i[k] && (bc_tag_i[k*TAG_W +: TAG_W] == tag_i);
  end

  assign hit_o = en_i && (|bus_hit);
endmodule

// File: rtl/alloc_pick.sv
module alloc_pick #(
  parameter int unsigned ENTRIES = 16,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] busy_i,
  output logic               free_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic [ENTRIES-1:0] onehot_o
);
  always_comb begin
    idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!busy_i[i]) idx_o = IDX_W'(i);
    end
    free_o   = ~&busy_i;
    onehot_o = '0;
    if (free_o) onehot_o[idx_o] = 1'b1;
  end
endmodule

// File: rtl/window_entry.sv
module window_entry
  import wakeup_pkg::*;
#(
  parameter int unsigned IW    = 4,
  parameter int unsigned TAG_W = 7
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [IW-1:0]         bc_valid_i,
  input  logic [IW*TAG_W-1:0]   bc_tag_i,
  input  logic                  load_i,
  input  logic [OPS*TAG_W-1:0]  ld_tag_i,
  input  logic [OPS-1:0]        ld_rdy_i,
  input  logic                  grant_i,
  output logic                  valid_o,
  output logic                  req_o
);
  logic                 valid_q;
  logic [OPS-1:0]       rdy_q, hit, rdy_now;
  logic [OPS*TAG_W-1:0] tag_q;

  for (genvar op = 0; op < OPS; op++) begin : g_op
    tag_match #(.IW(IW), .TAG_W(TAG_W)) u_match (
      .en_i      (valid_q),
      .tag_i     (tag_q[op*TAG_W +: TAG_W]),
      .bc_valid_i(bc_valid_i),
      .bc_tag_i  (bc_tag_i),
      .hit_o     (hit[op])
    );
    assign rdy_now[op] = rdy_q[op] | hit[op];
  end

  assign req_o   = valid_q && (&rdy_now);
  assign valid_o = valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      rdy_q   <= '0;
      tag_q   <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      rdy_q   <= ld_rdy_i;
      tag_q   <= ld_tag_i;
    end else begin
      rdy_q <= rdy_now;
      if (grant_i && req_o) valid_q <= 1'b0;
    end
  end

  assert_free_after_grant_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_i && req_o && !load_i) |=> !valid_o);
  assert_grant_needs_req_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !(grant_i && req_o) && !load_i) |=> valid_o);
  assert_wake_held_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && (&rdy_now) && !load_i) |=> (&rdy_q));
  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_o && !load_i) |=> !req_o);
endmodule

// File: rtl/issue_wakeup_window.sv
module issue_wakeup_window
  import wakeup_pkg::*;
#(
  parameter int unsigned ENTRIES  = 16,
  parameter int unsigned IW       = 4,
  parameter int unsigned TAG_W    = 7,
  parameter int unsigned NULL_TAG = 0,
  localparam int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  disp_valid_i,
  input  logic [2*TAG_W-1:0]    disp_tag_i,
  input  logic [1:0]            disp_rdy_i,
  output logic                  disp_ready_o,
  output logic [IDX_W-1:0]      disp_idx_o,
  input  logic [IW-1:0]         bc_valid_i,
  input  logic [IW*TAG_W-1:0]   bc_tag_i,
  input  logic [ENTRIES-1:0]    grant_i,
  output logic [ENTRIES-1:0]    valid_o,
  output logic [ENTRIES-1:0]    req_o
);
  logic [ENTRIES-1:0] slot_1h, load;
  logic [OPS-1:0]     in_hit, in_rdy;
  logic               disp_fire;

  alloc_pick #(.ENTRIES(ENTRIES)) u_alloc (
    .busy_i  (valid_o),
    .free_o  (disp_ready_o),
    .idx_o   (disp_idx_o),
    .onehot_o(slot_1h)
  );

  assign disp_fire = disp_valid_i && disp_ready_o;
  assign load      = disp_fire ? slot_1h : '0;

  // incoming tags see this cycle's broadcasts too
  for (genvar op = 0; op < OPS; op++) begin : g_in
    tag_match #(.IW(IW), .TAG_W(TAG_W)) u_in_match (
      .en_i      (disp_valid_i),
      .tag_i     (disp_tag_i[op*TAG_W +: TAG_W]),
      .bc_valid_i(bc_valid_i),
      .bc_tag_i  (bc_tag_i),
      .hit_o     (in_hit[op])
    );
    assign in_rdy[op] = disp_rdy_i[op] || in_hit[op] ||
                        (disp_tag_i[op*TAG_W +: TAG_W] == TAG_W'(NULL_TAG));
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    window_entry #(.IW(IW), .TAG_W(TAG_W)) u_entry (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .bc_valid_i(bc_valid_i),
      .bc_tag_i  (bc_tag_i),
      .load_i    (load[i]),
      .ld_tag_i  (disp_tag_i),
      .ld_rdy_i  (in_rdy),
      .grant_i   (grant_i[i]),
      .valid_o   (valid_o[i]),
      .req_o     (req_o[i])
    );
  end

  assert_alloc_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(load));
  assert_alloc_lands_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_fire |=> valid_o[$past(disp_idx_o)]);
  assert_full_blocks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&valid_o) |-> (!disp_ready_o && load == '0));
  assert_req_valid_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o & ~valid_o) == '0);
endmodule

// File: tb/tb_issue_wakeup_window.sv
module tb_issue_wakeup_window;
  localparam int N = 4, IW = 2, TW = 4;

  logic          clk_i = 1'b0, rst_ni = 1'b0;
  logic          disp_valid_i;
  logic [2*TW-1:0] disp_tag_i;
  logic [1:0]    disp_rdy_i;
  logic          disp_ready_o;
  logic [1:0]    disp_idx_o;
  logic [IW-1:0] bc_valid_i;
  logic [IW*TW-1:0] bc_tag_i;
  logic [N-1:0]  grant_i, valid_o, req_o;
  int checks = 0, errors = 0;

  always #10 clk_i = ~clk_i;

  issue_wakeup_window #(.ENTRIES(N), .IW(IW), .TAG_W(TW)) dut (.*);

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic idle();
    disp_valid_i = 0; disp_tag_i = '0; disp_rdy_i = '0;
    bc_valid_i = '0; bc_tag_i = '0; grant_i = '0;
  endtask

  task automatic cyc(); @(negedge clk_i); endtask

  task automatic do_reset();
    idle(); rst_ni = 0; cyc(); cyc(); rst_ni = 1; cyc();
  endtask

  task automatic disp(input int t0, input int t1, input logic [1:0] r);
    disp_valid_i = 1; disp_tag_i = {TW'(t1), TW'(t0)}; disp_rdy_i = r;
    cyc(); disp_valid_i = 0; disp_rdy_i = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset(); #2;
    chk(valid_o, 0, "R1 valid"); chk(req_o, 0, "R1 req");
    chk(disp_ready_o, 1, "R1 ready"); chk(disp_idx_o, 0, "R1 idx");

    // sweep source tag against broadcast tag, alternating buses
    for (int s = 0; s < 16; s++) begin
      for (int b = 0; b < 16; b++) begin
        do_reset();
        disp(s, 0, 2'b00); #2;
        chk(req_o[0], (s == 0), "R5 null tag ready");
        bc_valid_i = IW'(1 << (b % 2));
        bc_tag_i[(b % 2)*TW +: TW] = TW'(b); #2;
        chk(req_o[0], (s == 0 || s == b), "R2 R3 same-cycle wake");
        cyc(); bc_valid_i = '0; #2;
        chk(req_o[0], (s == 0 || s == b), "R2 wake held");
      end
    end

    // both operands on different buses in one cycle
    do_reset(); disp(3, 5, 2'b00); #2;
    chk(req_o, 0, "R4 not ready");
    bc_valid_i = 2'b10; bc_tag_i = {4'd3, 4'd0}; #2;
    chk(req_o, 0, "R4 one operand only");
    bc_valid_i = 2'b11; bc_tag_i = {4'd3, 4'd5}; #2;
    chk(req_o, 4'b0001, "R3 both buses");

    // broadcast during dispatch cycle
    do_reset();
    bc_valid_i = 2'b11; bc_tag_i = {4'd9, 4'd7};
    disp(7, 9, 2'b00); bc_valid_i = '0; #2;
    chk(req_o, 4'b0001, "R6 dispatch-cycle capture");

    // ready flags at dispatch
    do_reset(); disp(4, 6, 2'b11); #2;
    chk(req_o, 4'b0001, "R5 ready flags");
    disp(4, 6, 2'b01); #2;
    chk(req_o, 4'b0001, "R5 half ready waits");

    // invalid bus ignored
    do_reset(); disp(8, 0, 2'b00);
    bc_valid_i = 2'b00; bc_tag_i = {4'd8, 4'd8}; #2;
    chk(req_o, 0, "R10 invalid bus same cycle");
    cyc(); idle(); #2;
    chk(req_o, 0, "R10 invalid bus next cycle");
    chk(req_o & ~valid_o, 0, "R10 invalid slot quiet");

    // allocation order, full, grants
    do_reset();
    for (int k = 0; k < N; k++) begin
      #2 chk(disp_idx_o, k, "R8 lowest free");
      disp(k + 1, 0, 2'b00);
    end
    #2;
    chk(valid_o, 4'b1111, "R8 all filled");
    chk(disp_ready_o, 0, "R9 full");
    disp(0, 0, 2'b11); #2;
    chk(valid_o, 4'b1111, "R9 dispatch ignored");
    chk(req_o, 0, "R9 no new request");
    grant_i = 4'b0100; cyc(); grant_i = '0; #2;
    chk(valid_o, 4'b1111, "R7 grant without req ignored");
    bc_valid_i = 2'b10; bc_tag_i = {4'd3, 4'd0}; grant_i = 4'b0100; #2;
    chk(req_o, 4'b0100, "R2 wake slot 2");
    chk(valid_o[2], 1, "R7 valid during grant");
    cyc(); idle(); #2;
    chk(valid_o, 4'b1011, "R7 freed after grant");
    chk(disp_ready_o, 1, "R8 ready after free");
    chk(disp_idx_o, 2, "R8 reuse freed slot");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule